// File: doc/BRIEF.md
# DMA Channel Request Arbiter

This block chooses which channel of a multi-channel DMA controller moves its next data element. Each channel provides a 32-bit configuration word and a count of elements still to move. The block also sees two 32-line peripheral request inputs, one for single requests and one for burst requests. A channel can win only when all of these hold:

- The controller-wide enable is on.
- The channel itself is enabled and not halted.
- Its count of elements still to move is not zero.
- The peripheral requests that its flow-type field asks for are active.

The winner is offered to the transfer engine on a valid/ready grant interface, one element at a time.

The grant carries no data. The rules are these:

- While `gnt_valid` is high, `gnt_chan` stays fixed.
- The engine raises `gnt_ready` on the cycle the element is finished, and that handshake is the completion.
- The engine may hold `gnt_ready` low for as long as it needs. This back-pressure is the only stall mechanism.
- `gnt_ready` has no effect while `gnt_valid` is low.

After every completion the grant drops for one cycle. During that cycle eligibility is computed again from the inputs present, so any change to a configuration word, a count or a request line takes effect there.

Channels whose flow field asks for a peripheral-controlled mode are not served. They raise a per-channel `flow_err` flag instead.

Top module: `dma_req_arbiter`

## Requirements
- R1: When bit 0 of `glb_cfg` is 0, no new grant is issued.
- R2: A channel can be granted only if its configuration bit 0 (enable) is 1 and bit 18 (halt) is 0.
- R3: The source peripheral index is configuration bits [5:1] and the destination index is bits [10:6]. Each index selects one of 32 request lines. The request vector used is `preq_single` OR `preq_burst`.
- R4: Flow field bits [13:11] decide which requests are needed. Value 0 needs none, 1 needs the destination line, 2 needs the source line, and 3 needs both.
- R5: A channel with global enable, channel enable and no halt whose flow value is 4 to 7 is never granted. Its bit of `flow_err` reads 1 one clock after those inputs are present and 0 otherwise.
- R6: A channel whose remaining count is zero is never granted.
- R7: Once `gnt_valid` is high, it and `gnt_chan` stay unchanged until a cycle with `gnt_ready` high, whatever the other inputs do.
- R8: After a cycle with `gnt_valid` and `gnt_ready` both high, `gnt_valid` is low for the next cycle. A new grant is then decided from the inputs present in that idle cycle and is visible one clock later.
- R9: If the most recently completed channel is still eligible, it is granted again. Otherwise the lowest-numbered eligible channel wins.
- R10: After reset, `gnt_valid` is 0, `flow_err` is all zeros, and no channel is remembered as most recently completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| glb_cfg | input | 32 | Controller-wide configuration; bit 0 enables arbitration |
| ch_cfg | input | NUM_CH*32 | Per-channel configuration words; channel c occupies bits [c*32 +: 32] |
| ch_remain | input | NUM_CH*CNT_W | Per-channel remaining element counts |
| preq_single | input | 32 | Single-request lines from peripherals |
| preq_burst | input | 32 | Burst-request lines from peripherals |
| gnt_valid | output | 1 | A grant is offered |
| gnt_chan | output | CH_W | Granted channel number |
| gnt_ready | input | 1 | Engine finished the granted element (completion handshake) |
| flow_err | output | NUM_CH | Per-channel flag for an unsupported flow mode |

## Verification
The hardest situation to reach from the ports is the sticky case. A channel that is not the lowest eligible one must have just completed and must still be eligible, while a lower-numbered channel has also become eligible. Reaching it needs a completion on a higher channel first, followed by a change of inputs during the idle cycle. The stimulus builds this with a directed sequence. It also uses random runs that often keep configurations and vary only request lines and counts between elements, so that the last winner frequently stays eligible next to new competitors. Random hold phases that change every input while a grant waits for `gnt_ready` check that the offer cannot be disturbed.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  localparam int CFG_W    = 32;
  localparam int IDX_W    = 5;
  localparam int REQ_N    = 1 << IDX_W;
  localparam int FLOW_W   = 3;

  localparam int EN_BIT   = 0;
  localparam int SRC_LSB  = 1;
  localparam int DST_LSB  = 6;
  localparam int FLOW_LSB = 11;
  localparam int HALT_BIT = 18;

  typedef logic [FLOW_W-1:0] flow_t;

  localparam flow_t FLOW_FREE = 3'd0;
  localparam flow_t FLOW_DST  = 3'd1;
  localparam flow_t FLOW_SRC  = 3'd2;
  localparam flow_t FLOW_BOTH = 3'd3;

  typedef struct packed {
    logic             on;
    logic             stop;
    logic [IDX_W-1:0] src_idx;
    logic [IDX_W-1:0] dst_idx;
    flow_t            flow;
  } ch_view_t;

  function automatic ch_view_t view_cfg(input logic [CFG_W-1:0] w);
    ch_view_t v;
    v.on      = w[EN_BIT];
    v.stop    = w[HALT_BIT];
    v.src_idx = w[SRC_LSB +: IDX_W];
    v.dst_idx = w[DST_LSB +: IDX_W];
    v.flow    = w[FLOW_LSB +: FLOW_W];
    return v;
  endfunction

endpackage

// File: rtl/dma_arb_chan_elig.sv
module dma_arb_chan_elig
  import dma_arb_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             glb_on,
  input  logic [CFG_W-1:0] cfg,
  input  logic [CNT_W-1:0] remain,
  input  logic [REQ_N-1:0] req_vec,
  output logic             elig,
  output logic             flow_bad
);

  ch_view_t v;
  logic     candidate;
  logic     src_hit;
  logic     dst_hit;
  logic     req_ok;
  logic     has_work;

  always_comb begin
    v         = view_cfg(cfg);
    candidate = glb_on && v.on && !v.stop;
    src_hit   = req_vec[v.src_idx];
    dst_hit   = req_vec[v.dst_idx];
    has_work  = (remain != '0);
    unique case (v.flow)
      FLOW_FREE: req_ok = 1'b1;
      FLOW_DST:  req_ok = dst_hit;
      FLOW_SRC:  req_ok = src_hit;
      FLOW_BOTH: req_ok = src_hit && dst_hit;
      default:   req_ok = 1'b0;
    endcase
    flow_bad  = candidate && v.flow[FLOW_W-1];
    elig      = candidate && !v.flow[FLOW_W-1] && req_ok && has_work;
  end

endmodule

// File: rtl/dma_arb_pick.sv
module dma_arb_pick #(
  parameter int NUM_CH = 8,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH-1:0] elig,
  input  logic              prev_vld,
  input  logic [CH_W-1:0]   prev_ch,
  output logic              pick_vld,
  output logic [CH_W-1:0]   pick_ch
);

  logic            low_vld;
  logic [CH_W-1:0] low_ch;
  logic            keep_prev;

  always_comb begin
    low_vld = 1'b0;
    low_ch  = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (elig[i]) begin
        low_vld = 1'b1;
        low_ch  = CH_W'(i);
      end
    end
  end

  assign keep_prev = prev_vld && elig[prev_ch];
  assign pick_vld  = low_vld;
  assign pick_ch   = keep_prev ? prev_ch : low_ch;

endmodule

// File: rtl/dma_arb_gnt.sv
module dma_arb_gnt #(
  parameter int NUM_CH = 8,
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pick_vld,
  input  logic [CH_W-1:0] pick_ch,
  input  logic            gnt_ready,
  output logic            gnt_valid,
  output logic [CH_W-1:0] gnt_chan,
  output logic            prev_vld,
  output logic [CH_W-1:0] prev_ch
);

  logic done;
  assign done = gnt_valid && gnt_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_valid <= 1'b0;
      gnt_chan  <= '0;
      prev_vld  <= 1'b0;
      prev_ch   <= '0;
    end else if (done) begin
      gnt_valid <= 1'b0;
      prev_vld  <= 1'b1;
      prev_ch   <= gnt_chan;
    end else if (!gnt_valid && pick_vld) begin
      gnt_valid <= 1'b1;
      gnt_chan  <= pick_ch;
    end
  end

endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CNT_W  = 12,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [CFG_W-1:0]        glb_cfg,
  input  logic [NUM_CH*CFG_W-1:0] ch_cfg,
  input  logic [NUM_CH*CNT_W-1:0] ch_remain,
  input  logic [REQ_N-1:0]        preq_single,
  input  logic [REQ_N-1:0]        preq_burst,
  output logic                    gnt_valid,
  output logic [CH_W-1:0]         gnt_chan,
  input  logic                    gnt_ready,
  output logic [NUM_CH-1:0]       flow_err
);

  logic [REQ_N-1:0]  req_vec;
  logic [NUM_CH-1:0] elig;
  logic [NUM_CH-1:0] bad;
  logic              pick_vld;
  logic [CH_W-1:0]   pick_ch;
  logic              prev_vld;
  logic [CH_W-1:0]   prev_ch;

  assign req_vec = preq_single | preq_burst;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dma_arb_chan_elig #(.CNT_W(CNT_W)) u_elig (
      .glb_on   (glb_cfg[0]),
      .cfg      (ch_cfg[c*CFG_W +: CFG_W]),
      .remain   (ch_remain[c*CNT_W +: CNT_W]),
      .req_vec  (req_vec),
      .elig     (elig[c]),
      .flow_bad (bad[c])
    );
  end

  dma_arb_pick #(.NUM_CH(NUM_CH)) u_pick (
    .elig     (elig),
    .prev_vld (prev_vld),
    .prev_ch  (prev_ch),
    .pick_vld (pick_vld),
    .pick_ch  (pick_ch)
  );

  dma_arb_gnt #(.NUM_CH(NUM_CH)) u_gnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .pick_vld  (pick_vld),
    .pick_ch   (pick_ch),
    .gnt_ready (gnt_ready),
    .gnt_valid (gnt_valid),
    .gnt_chan  (gnt_chan),
    .prev_vld  (prev_vld),
    .prev_ch   (prev_ch)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flow_err <= '0;
    else        flow_err <= bad;
  end

endmodule

// File: rtl/dma_req_arbiter_chk.sv
module dma_req_arbiter_chk
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [CFG_W-1:0]        glb_cfg,
  input logic [NUM_CH*CFG_W-1:0] ch_cfg,
  input logic                    gnt_valid,
  input logic [CH_W-1:0]         gnt_chan,
  input logic                    gnt_ready,
  input logic [NUM_CH-1:0]       flow_err
);

  logic [NUM_CH*CFG_W-1:0] cfg_q;
  logic [CFG_W-1:0]        won_cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= ch_cfg;
  end

  assign won_cfg = cfg_q[gnt_chan*CFG_W +: CFG_W];

  AST_GNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid && !gnt_ready |=> gnt_valid && $stable(gnt_chan)); // R7

  AST_IDLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid && gnt_ready |=> !gnt_valid); // R8

  AST_GLB_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !gnt_valid && !glb_cfg[0] |=> !gnt_valid); // R1

  AST_WIN_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnt_valid) |-> won_cfg[EN_BIT] && !won_cfg[HALT_BIT]); // R2

  AST_WIN_FLOW_OK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnt_valid) |-> !won_cfg[FLOW_LSB + FLOW_W - 1]); // R5

  AST_ERR_NOT_WON: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnt_valid) |-> !flow_err[gnt_chan]); // R5

endmodule

bind dma_req_arbiter dma_req_arbiter_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .glb_cfg   (glb_cfg),
  .ch_cfg    (ch_cfg),
  .gnt_valid (gnt_valid),
  .gnt_chan  (gnt_chan),
  .gnt_ready (gnt_ready),
  .flow_err  (flow_err)
);

// File: tb/dma_req_arbiter_tb.sv
`timescale 1ns/1ps
module dma_req_arbiter_tb;

  localparam int NCH = 8;
  localparam int CW  = 12;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [31:0]     glb_cfg = '0;
  logic [NCH*32-1:0] ch_cfg = '0;
  logic [NCH*CW-1:0] ch_remain = '0;
  logic [31:0]     preq_single = '0;
  logic [31:0]     preq_burst = '0;
  logic            gnt_valid;
  logic [2:0]      gnt_chan;
  logic            gnt_ready = 1'b0;
  logic [NCH-1:0]  flow_err;

  dma_req_arbiter #(.NUM_CH(NCH), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .glb_cfg(glb_cfg), .ch_cfg(ch_cfg),
    .ch_remain(ch_remain), .preq_single(preq_single), .preq_burst(preq_burst),
    .gnt_valid(gnt_valid), .gnt_chan(gnt_chan), .gnt_ready(gnt_ready),
    .flow_err(flow_err)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  logic [31:0]   glb_m;
  logic [31:0]   cfg_m [NCH];
  logic [CW-1:0] rem_m [NCH];
  logic [31:0]   sreq_m, breq_m;
  bit            last_vld_m = 0;
  int            last_m = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drive();
    glb_cfg     = glb_m;
    preq_single = sreq_m;
    preq_burst  = breq_m;
    for (int c = 0; c < NCH; c++) begin
      ch_cfg[c*32 +: 32]  = cfg_m[c];
      ch_remain[c*CW +: CW] = rem_m[c];
    end
  endtask

  function automatic logic [31:0] mk_cfg(bit en, bit halt, int flow, int src, int dst);
    logic [31:0] w = '0;
    w[0] = en; w[18] = halt; w[13:11] = 3'(flow); w[5:1] = 5'(src); w[10:6] = 5'(dst);
    return w;
  endfunction

  function automatic bit m_elig(int c);
    logic [31:0] w  = cfg_m[c];
    logic [31:0] rq = sreq_m | breq_m;
    if (!glb_m[0] || !w[0] || w[18] || rem_m[c] == 0) return 0;
    case (w[13:11])
      3'd0: return 1;
      3'd1: return rq[w[10:6]];
      3'd2: return rq[w[5:1]];
      3'd3: return rq[w[5:1]] && rq[w[10:6]];
      default: return 0;
    endcase
  endfunction

  function automatic logic [NCH-1:0] m_err();
    logic [NCH-1:0] e = '0;
    for (int c = 0; c < NCH; c++)
      e[c] = glb_m[0] && cfg_m[c][0] && !cfg_m[c][18] && cfg_m[c][13];
    return e;
  endfunction

  task automatic clear_all();
    glb_m = 32'h1; sreq_m = '0; breq_m = '0;
    for (int c = 0; c < NCH; c++) begin cfg_m[c] = '0; rem_m[c] = '0; end
  endtask

  task automatic rand_all();
    glb_m = ($urandom % 8 != 0) ? 32'h1 : 32'h0;
    sreq_m = $urandom & $urandom;
    breq_m = $urandom & $urandom;
    for (int c = 0; c < NCH; c++) begin
      int fl = ($urandom % 8 == 0) ? 4 + int'($urandom % 4) : int'($urandom % 4);
      cfg_m[c] = mk_cfg($urandom % 4 != 0, $urandom % 5 == 0, fl,
                        int'($urandom % 32), int'($urandom % 32));
      rem_m[c] = CW'($urandom % 4);
    end
  endtask

  // One arbitration round: present inputs, check the grant, complete it.
  task automatic step(input string tag, input bit do_hold);
    bit ev = 0;
    int ec = 0;
    logic [NCH-1:0] ee;
    if (last_vld_m && m_elig(last_m)) begin ev = 1; ec = last_m; end
    else for (int c = NCH - 1; c >= 0; c--) if (m_elig(c)) begin ev = 1; ec = c; end
    ee = m_err();
    drive();
    @(negedge clk);
    chk(gnt_valid == ev, {tag, " valid"}, gnt_valid, ev);
    if (ev) chk(gnt_chan == 3'(ec), {tag, " chan"}, gnt_chan, ec);
    chk(flow_err == ee, "R5 flow_err", flow_err, ee);
    if (ev && gnt_valid) begin
      if (do_hold) begin
        rand_all();
        drive();
        repeat (3) @(negedge clk);
        chk(gnt_valid && gnt_chan == 3'(ec), "R7 hold", gnt_chan, ec);
      end
      gnt_ready = 1'b1;
      @(negedge clk);
      gnt_ready = 1'b0;
      chk(!gnt_valid, "R8 idle gap", gnt_valid, 0);
      last_vld_m = 1; last_m = ec;
      if (rem_m[ec] != 0) rem_m[ec] = rem_m[ec] - 1'b1;
    end
  endtask

  initial begin
    void'($urandom(32'd7351));
    clear_all();
    glb_m = '0;
    drive();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!gnt_valid, "R10 reset valid", gnt_valid, 0);
    chk(flow_err == '0, "R10 reset flow_err", flow_err, 0);

    // R1: global enable off blocks everything
    clear_all(); glb_m = 32'h0;
    cfg_m[0] = mk_cfg(1, 0, 0, 0, 0); rem_m[0] = 5;
    step("R1 global off", 0);
    // R2: halted channel is skipped, next channel wins
    glb_m = 32'h1; cfg_m[0][18] = 1'b1;
    cfg_m[2] = mk_cfg(1, 0, 0, 0, 0); rem_m[2] = 3;
    step("R2 halt skip", 0);
    // R3/R4: destination request via burst line 17 only
    clear_all();
    cfg_m[1] = mk_cfg(1, 0, 1, 3, 17); rem_m[1] = 2;
    step("R4 dst missing", 0);
    breq_m[17] = 1'b1;
    step("R3 burst dst", 0);
    // R4: both needed, only source present through single line 3
    clear_all();
    cfg_m[4] = mk_cfg(1, 0, 3, 3, 22); rem_m[4] = 2; sreq_m[3] = 1'b1;
    step("R4 both partial", 0);
    breq_m[22] = 1'b1;
    step("R4 both present", 0);
    // R5: unsupported flow value
    clear_all();
    cfg_m[0] = mk_cfg(1, 0, 6, 0, 0); rem_m[0] = 4;
    step("R5 bad flow", 0);
    // R6: zero count
    clear_all();
    cfg_m[3] = mk_cfg(1, 0, 0, 0, 0); rem_m[3] = 0;
    step("R6 zero count", 0);
    // R9: sticky winner then fallback to lowest
    clear_all();
    cfg_m[5] = mk_cfg(1, 0, 0, 0, 0); rem_m[5] = 3;
    step("R9 setup", 0);
    cfg_m[1] = mk_cfg(1, 0, 0, 0, 0); rem_m[1] = 3;
    step("R9 sticky", 1);
    clear_all();
    cfg_m[5] = mk_cfg(1, 0, 0, 0, 0); rem_m[5] = 0;
    cfg_m[1] = mk_cfg(1, 0, 0, 0, 0); rem_m[1] = 3;
    cfg_m[6] = mk_cfg(1, 0, 0, 0, 0); rem_m[6] = 3;
    step("R9 fallback lowest", 0);

    // Random rounds
    rand_all();
    for (int k = 0; k < 3000; k++) begin
      if ($urandom % 3 == 0) rand_all();
      else begin
        sreq_m = $urandom & $urandom;
        breq_m = $urandom & $urandom;
      end
      step("R9 random pick", $urandom % 4 == 0);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule